// File: doc/BRIEF.md
# Segmented Address and Read-Data Width Adapter

This block joins a full-width target transaction interface to a narrow segmented bus used when a port is run with fewer pins. On the inbound side, address segments arrive one per clock. Each segment carries a burst flag and a dual-address flag above its address bits. The low segment comes first, and a last-segment strobe marks the segment that finishes the address. The adapter rebuilds the full address and presents it with its two flags as a one-cycle valid pulse.

On the outbound side, the adapter takes full-width read words through a valid/ready handshake. It sends each word as a series of narrow segments, least significant segment first, under a second valid/ready handshake. It raises a last-segment flag only on the final segment of the final word of a burst. A stall from the narrow side holds the segment position, so the halves of a word never change order.

The word and segment widths are parameters. With the defaults, a 32-bit word travels as two 16-bit segments.

Top module: `seg_width_adapter`

## Requirements
- R1: An address sent as two segments, low segment (aseg_last=0) then high segment (aseg_last=1), comes out as addr_word = {high, low}.
- R2: On aseg_data, bit 17 is the burst flag and bit 16 is the dual-address flag. addr_burst and addr_dual take these bits from the segment that carries aseg_last=1.
- R3: A segment that carries aseg_last=1 when no low segment is pending is a complete address. addr_word then holds that segment in bits 15:0 and zero in bits 31:16.
- R4: addr_valid is high for exactly the one cycle after the clock edge that accepts a segment with aseg_valid=1 and aseg_last=1, and is low at all other times.
- R5: Idle cycles (aseg_valid=0) between the low and high segments do not change the assembled address.
- R6: A burst of N read words comes out as 2N segments: for each word, bits 15:0 first, then bits 31:16. rseg_valid follows rword_valid.
- R7: rseg_last is 1 only while the high segment of a word presented with rword_last=1 is on rseg_data. It is 0 on every other segment.
- R8: While rseg_ready is 0, the segment position and rseg_data stay unchanged. rword_ready is 1 only in the cycle that the high segment is accepted.
- R9: Reset makes addr_valid 0, clears any half-assembled address, and returns the read side to the low segment of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aseg_valid | input | 1 | An address segment is present |
| aseg_data | input | 18 | Bit 17 burst, bit 16 dual-address, bits 15:0 address segment |
| aseg_last | input | 1 | This segment completes the address |
| addr_valid | output | 1 | One-cycle pulse: the assembled address is valid |
| addr_word | output | 32 | Assembled address |
| addr_burst | output | 1 | Burst flag of the assembled address |
| addr_dual | output | 1 | Dual-address flag of the assembled address |
| rword_valid | input | 1 | A read word is offered |
| rword_ready | output | 1 | The read word is consumed this cycle |
| rword_data | input | 32 | Read word |
| rword_last | input | 1 | This word is the last of the burst |
| rseg_valid | output | 1 | A read segment is offered |
| rseg_ready | input | 1 | The narrow side accepts the segment |
| rseg_data | output | 16 | Read segment |
| rseg_last | output | 1 | Final segment of the burst |

## Verification
The assertions check on every cycle the following rules. Each address pulse traces back to an accepted final segment, and the flags come from that segment. The last-segment flag appears only with a last word. A word is consumed only when the narrow side is ready. The segment on the bus stays put during a stall. Only the bench's scenarios can show the assembled address values, the single-segment case, and the segment order across bursts of different lengths under varied stall patterns. The bench also checks that reset in the middle of a transfer discards a half-built address and restarts a word at its low segment.

// File: rtl/seg_adapter_pkg.sv
package seg_adapter_pkg;
   // flag positions above the segment payload on the inbound bus
   localparam int FLAG_BURST_OFS = 1;
   localparam int FLAG_DUAL_OFS  = 0;
   localparam int FLAG_BITS      = 2;

   typedef struct packed {
      logic burst;
      logic dual;
   } seg_flags_t;

   function automatic int seg_count(input int word_w, input int seg_w);
      return word_w / seg_w;
   endfunction
endpackage

// File: rtl/seg_addr_assembler.sv
module seg_addr_assembler
   import seg_adapter_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SEG_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [SEG_W+FLAG_BITS-1:0] in_data,
   input  logic                       in_last,
   output logic                       out_valid,
   output logic [WORD_W-1:0]          out_word,
   output seg_flags_t                 out_flags
);
   localparam int NSEG  = seg_count(WORD_W, SEG_W);
   localparam int IDX_W = $clog2(NSEG);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NSEG - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [SEG_W-1:0]  slot_q [NSEG];
   logic [WORD_W-1:0] word_nxt;
   logic [SEG_W-1:0]  payload;
   seg_flags_t        flags_in;

   assign payload        = in_data[SEG_W-1:0];
   assign flags_in.burst = in_data[SEG_W+FLAG_BURST_OFS];
   assign flags_in.dual  = in_data[SEG_W+FLAG_DUAL_OFS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (in_valid) begin
         if (in_last)
            idx_q <= '0;
         else if (idx_q != TOP_IDX)
            idx_q <= idx_q + 1'b1;
      end
   end

   for (genvar k = 0; k < NSEG; k++) begin : g_slot
      localparam logic [IDX_W-1:0] KI = IDX_W'(k);
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[k] <= '0;
         else if (in_valid && in_last)
            slot_q[k] <= '0;
         else if (in_valid && idx_q == KI)
            slot_q[k] <= payload;
      end
      assign word_nxt[k*SEG_W +: SEG_W] = (KI < idx_q)  ? slot_q[k] :
                                          (KI == idx_q) ? payload   : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_flags <= '0;
      end else begin
         out_valid <= in_valid && in_last;
         if (in_valid && in_last) begin
            out_word  <= word_nxt;
            out_flags <= flags_in;
         end
      end
   end
endmodule

// File: rtl/seg_read_splitter.sv
module seg_read_splitter
   import seg_adapter_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SEG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   output logic              word_ready,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_last,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [SEG_W-1:0]  seg_data,
   output logic              seg_last
);
   localparam int NSEG  = seg_count(WORD_W, SEG_W);
   localparam int IDX_W = $clog2(NSEG);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NSEG - 1);

   logic [IDX_W-1:0] idx_q;
   logic [SEG_W-1:0] pieces [NSEG];
   logic             at_top;

   for (genvar k = 0; k < NSEG; k++) begin : g_piece
      assign pieces[k] = word_data[k*SEG_W +: SEG_W];
   end

   assign at_top     = (idx_q == TOP_IDX);
   assign seg_valid  = word_valid;
   assign seg_data   = pieces[idx_q];
   assign seg_last   = word_valid && word_last && at_top;
   assign word_ready = word_valid && seg_ready && at_top;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (word_valid && seg_ready)
         idx_q <= at_top ? '0 : idx_q + 1'b1;
   end
endmodule

// File: rtl/seg_width_adapter.sv
module seg_width_adapter
   import seg_adapter_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SEG_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       aseg_valid,
   input  logic [SEG_W+FLAG_BITS-1:0] aseg_data,
   input  logic                       aseg_last,
   output logic                       addr_valid,
   output logic [WORD_W-1:0]          addr_word,
   output logic                       addr_burst,
   output logic                       addr_dual,
   input  logic                       rword_valid,
   output logic                       rword_ready,
   input  logic [WORD_W-1:0]          rword_data,
   input  logic                       rword_last,
   output logic                       rseg_valid,
   input  logic                       rseg_ready,
   output logic [SEG_W-1:0]           rseg_data,
   output logic                       rseg_last
);
   if (SEG_W < 1 || WORD_W % SEG_W != 0) begin : g_bad_ratio
      $error("WORD_W must be a whole multiple of SEG_W");
   end
   if (WORD_W / SEG_W < 2) begin : g_bad_count
      $error("WORD_W must hold at least two segments");
   end

   seg_flags_t flags;

   seg_addr_assembler #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (aseg_valid),
      .in_data   (aseg_data),
      .in_last   (aseg_last),
      .out_valid (addr_valid),
      .out_word  (addr_word),
      .out_flags (flags)
   );
   assign addr_burst = flags.burst;
   assign addr_dual  = flags.dual;

   seg_read_splitter #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_split (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (rword_valid),
      .word_ready (rword_ready),
      .word_data  (rword_data),
      .word_last  (rword_last),
      .seg_valid  (rseg_valid),
      .seg_ready  (rseg_ready),
      .seg_data   (rseg_data),
      .seg_last   (rseg_last)
   );
endmodule

// File: rtl/seg_width_adapter_chk.sv
module seg_width_adapter_chk #(
   parameter int WORD_W = 32,
   parameter int SEG_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              aseg_valid,
   input logic [SEG_W+1:0]  aseg_data,
   input logic              aseg_last,
   input logic              addr_valid,
   input logic              addr_burst,
   input logic              addr_dual,
   input logic              rword_valid,
   input logic              rword_ready,
   input logic [WORD_W-1:0] rword_data,
   input logic              rword_last,
   input logic              rseg_ready,
   input logic [SEG_W-1:0]  rseg_data,
   input logic              rseg_last
);
   // R4
   addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> $past(aseg_valid && aseg_last));

   // R2
   addr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (addr_burst == $past(aseg_data[SEG_W+1]) &&
                      addr_dual  == $past(aseg_data[SEG_W])));

   // R7
   rlast_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rseg_last |-> (rword_valid && rword_last));

   // R8
   rconsume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rword_ready |-> (rseg_ready && rword_valid));

   // R8
   rhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rword_valid && !rseg_ready) |=>
         (rseg_data == $past(rseg_data) || rword_data != $past(rword_data)));
endmodule

bind seg_width_adapter seg_width_adapter_chk #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .aseg_valid  (aseg_valid),
   .aseg_data   (aseg_data),
   .aseg_last   (aseg_last),
   .addr_valid  (addr_valid),
   .addr_burst  (addr_burst),
   .addr_dual   (addr_dual),
   .rword_valid (rword_valid),
   .rword_ready (rword_ready),
   .rword_data  (rword_data),
   .rword_last  (rword_last),
   .rseg_ready  (rseg_ready),
   .rseg_data   (rseg_data),
   .rseg_last   (rseg_last)
);

// File: tb/tb_seg_width_adapter.sv
`timescale 1ns/1ps
module tb_seg_width_adapter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aseg_valid = 1'b0;
   logic [17:0] aseg_data = '0;
   logic        aseg_last = 1'b0;
   logic        addr_valid;
   logic [31:0] addr_word;
   logic        addr_burst, addr_dual;
   logic        rword_valid = 1'b0;
   logic        rword_ready;
   logic [31:0] rword_data = '0;
   logic        rword_last = 1'b0;
   logic        rseg_valid;
   logic        rseg_ready = 1'b0;
   logic [15:0] rseg_data;
   logic        rseg_last;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   seg_width_adapter dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      aseg_valid = 1'b0;
      rword_valid = 1'b0;
      rseg_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send_seg(input logic [15:0] d, input logic b, input logic du, input logic last);
      @(negedge clk);
      aseg_valid = 1'b1;
      aseg_data  = {b, du, d};
      aseg_last  = last;
   endtask

   task automatic idle_seg(input int n);
      for (int g = 0; g < n; g++) begin
         @(negedge clk);
         aseg_valid = 1'b0;
         aseg_data  = 18'h3ABCD;
         aseg_last  = 1'b1;
      end
   endtask

   task automatic check_addr(input string req, input logic [31:0] exp_a, input logic b, input logic du);
      @(negedge clk);
      aseg_valid = 1'b0;
      aseg_last  = 1'b0;
      check({req, " valid"}, 32'(addr_valid), 32'd1);
      check({req, " addr"}, addr_word, exp_a);
      check("R2 burst", 32'(addr_burst), 32'(b));
      check("R2 dual", 32'(addr_dual), 32'(du));
      @(negedge clk);
      check("R4 pulse ends", 32'(addr_valid), 32'd0);
   endtask

   function automatic logic [31:0] rd_word(input int n, input int w);
      return (32'(n) * 32'h0101_0F1F) ^ (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_00FF;
   endfunction

   task automatic read_burst(input int n, input int p);
      int cyc = 0;
      for (int w = 0; w < n; w++) begin
         logic [31:0] d;
         d = rd_word(n, w);
         for (int h = 0; h < 2; h++) begin
            bit taken = 0;
            while (!taken) begin
               bit rdy;
               rdy = (p == 0) || ((cyc % (p + 1)) != 0);
               cyc++;
               @(negedge clk);
               rword_valid = 1'b1;
               rword_data  = d;
               rword_last  = (w == n - 1);
               rseg_ready  = rdy;
               #1;
               check("R6 seg valid", 32'(rseg_valid), 32'd1);
               check(h == 0 ? "R6 low half" : "R6 high half", 32'(rseg_data),
                     h == 0 ? 32'(d[15:0]) : 32'(d[31:16]));
               check("R7 seg last", 32'(rseg_last), 32'((w == n - 1) && (h == 1)));
               check("R8 word ready", 32'(rword_ready), 32'(rdy && (h == 1)));
               taken = rdy;
            end
         end
      end
      @(negedge clk);
      rword_valid = 1'b0;
      rword_last  = 1'b0;
      rseg_ready  = 1'b0;
      #1;
      check("R6 idle valid", 32'(rseg_valid), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R9 reset valid", 32'(addr_valid), 32'd0);
      check("R9 reset word", addr_word, 32'd0);
      check("R9 reset rseg_valid", 32'(rseg_valid), 32'd0);
      check("R9 reset rseg_last", 32'(rseg_last), 32'd0);

      // address sweep: R1 two-segment, R3 single segment, R5 gaps, R2 flags
      for (int i = 0; i < 64; i++) begin
         logic [31:0] a;
         logic b, du;
         int gap;
         a   = (32'(i) * 32'h9E37_79B1) ^ (32'(i) << 7) ^ 32'hC0DE_0001;
         b   = i[1];
         du  = i[0];
         gap = (i / 4) % 4;
         if (i % 8 == 7) begin
            send_seg(a[15:0], b, du, 1'b1);
            check_addr("R3 single", {16'h0, a[15:0]}, b, du);
         end else begin
            send_seg(a[15:0], ~b, ~du, 1'b0);
            idle_seg(gap);
            if (gap != 0) check("R5 no early valid", 32'(addr_valid), 32'd0);
            send_seg(a[31:16], b, du, 1'b1);
            check_addr(gap != 0 ? "R5 gapped" : "R1 pair", a, b, du);
         end
      end

      // read sweep: R6 R7 R8
      for (int p = 0; p < 3; p++)
         for (int n = 1; n <= 5; n++)
            read_burst(n, p);

      // R9: reset discards a half-built address
      send_seg(16'hBEEF, 1'b0, 1'b0, 1'b0);
      do_reset();
      send_seg(16'h1234, 1'b1, 1'b0, 1'b1);
      check_addr("R9 partial cleared", 32'h0000_1234, 1'b1, 1'b0);

      // R9: reset returns read side to the low half
      @(negedge clk);
      rword_valid = 1'b1;
      rword_data  = 32'hCAFE_F00D;
      rword_last  = 1'b1;
      rseg_ready  = 1'b1;
      do_reset();
      @(negedge clk);
      rword_valid = 1'b1;
      rword_data  = 32'hCAFE_F00D;
      rword_last  = 1'b1;
      rseg_ready  = 1'b0;
      #1;
      check("R9 read low after reset", 32'(rseg_data), 32'h0000_F00D);
      check("R9 read last after reset", 32'(rseg_last), 32'd0);
      @(negedge clk);
      rword_valid = 1'b0;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule